// File: doc/BRIEF.md
# Terminal Keyboard/Display Register Block

This peripheral gives a processor a character terminal through four word-sized registers on a simple synchronous load/store port. Two registers serve keyboard input: a receive control register holding a ready flag and an interrupt enable, and a receive data register holding the last captured key. The other two serve display output: a transmit control register with the same two flags, and a transmit data register that takes the next character to show.

The ready flags change as a side effect of data-register traffic. A key arriving from the device side sets receive ready, and a processor read of the receive character clears it. A processor write of a transmit character clears transmit ready. The block then models a busy display for a fixed number of cycles. At the end of that time it strobes the character out for one cycle and sets ready again. Each unit raises its own interrupt request while its ready flag and its enable are both set. Software can therefore poll the control registers or run from interrupts.

Top module: `term_mmio`

## Requirements
- R1: After reset, both interrupt enables are 0, receive ready is 0, transmit ready is 1, both stored characters are 0, and the display strobe is low.
- R2: The registers are word-addressed from BASE (default 0xFFFF0000): receive control at +0x0, receive data at +0x4, transmit control at +0x8, transmit data at +0xC. Read data is returned combinationally in the same cycle as the read enable. It is zero for any other address and whenever no read is requested.
- R3: In both control registers, bit 0 reads the ready flag and ignores writes. Bit 1 is a read/write interrupt enable. Bits 31:2 read as zero, and data registers read zero in bits 31:8.
- R4: A cycle with the key-valid input high stores the key byte in receive data bits 7:0 and sets receive ready at the next edge.
- R5: A read of receive data clears receive ready at the next edge unless a key arrives in that cycle. Writes to receive data are ignored.
- R6: A write to transmit data stores bits 7:0 as the character, which reads back at +0xC, and clears transmit ready at the next edge.
- R7: After a transmit data write, transmit ready stays 0 for exactly BUSY_CYCLES cycles. The display strobe is high for one cycle, the last of those cycles, with the character on the display byte output. Ready is 1 in the following cycle.
- R8: A transmit data write while the display is busy replaces the character and restarts the full busy interval. Only the new character is strobed.
- R9: A key arriving while receive ready is 1 overwrites the stored byte and leaves ready at 1. A receive data read in the same cycle as a new key also leaves ready at 1.
- R10: Each interrupt request output is high exactly when that unit's ready flag and interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read enable |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| kb_valid | input | 1 | Key byte present this cycle |
| kb_byte | input | 8 | Incoming key byte |
| disp_strobe | output | 1 | One-cycle pulse: display takes the character |
| disp_byte | output | 8 | Character presented to the display |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
On every cycle the assertions check the flag side effects: a key sets receive ready, a lone receive data read clears it, and a transmit data write clears transmit ready. They also check that the strobe is a single pulse inside the busy window and the only way transmit ready returns, that interrupt requests follow flag and enable, and that unused read bits and unmapped reads are zero. Other behaviours need the bench's scenarios. These are the exact busy-window length and the strobed byte value, the restart on a write during busy, the overwrite and simultaneous read-and-key cases, and the ignored writes to read-only bits and registers. The reset state, including a reset taken in the middle of a busy interval, is also shown only by the scenarios.

// File: rtl/term_mmio_pkg.sv
package term_mmio_pkg;
    localparam int DATA_W   = 32;
    localparam int CHAR_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int BIT_RDY  = 0;
    localparam int BIT_IE   = 1;

    typedef enum logic [1:0] {
        REG_RX_CTRL = 2'd0,
        REG_RX_DATA = 2'd1,
        REG_TX_CTRL = 2'd2,
        REG_TX_DATA = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ready;
        logic              ie;
    } rx_state_t;
endpackage

// File: rtl/term_addr_dec.sv
module term_addr_dec
    import term_mmio_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd,
    input  logic                wr,
    output logic [NUM_REGS-1:0] rd_sel,
    output logic [NUM_REGS-1:0] wr_sel
);
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int TAG_LSB = IDX_LSB + IDX_W;

    logic hit;

    always_comb begin
        hit = (addr[ADDR_W-1:TAG_LSB] == BASE[ADDR_W-1:TAG_LSB])
           && (addr[IDX_LSB-1:0] == '0);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign rd_sel[g] = rd && hit && (addr[TAG_LSB-1:IDX_LSB] == IDX_W'(g));
        assign wr_sel[g] = wr && hit && (addr[TAG_LSB-1:IDX_LSB] == IDX_W'(g));
    end
endmodule

// File: rtl/term_rx_unit.sv
module term_rx_unit
    import term_mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_byte,
    input  logic              ctrl_wr,
    input  logic              ie_wval,
    input  logic              data_rd,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] data
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ie = ie_wval;
        end
        if (key_valid) begin
            st_d.data  = key_byte;
            st_d.ready = 1'b1;
        end else if (data_rd) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;
    assign ie    = st_q.ie;
    assign data  = st_q.data;
endmodule

// File: rtl/term_tx_unit.sv
module term_tx_unit
    import term_mmio_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ie_wval,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] data,
    output logic              strobe
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              ready;
        logic              ie;
        logic [CNT_W-1:0]  cnt;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      last_d;

    always_comb begin
        st_d   = st_q;
        last_d = !st_q.ready && (st_q.cnt == CNT_W'(1));
        if (ctrl_wr) begin
            st_d.ie = ie_wval;
        end
        if (data_wr) begin
            st_d.data  = wchar;
            st_d.ready = 1'b0;
            st_d.cnt   = CNT_W'(BUSY_CYCLES);
        end else if (!st_q.ready) begin
            if (last_d) begin
                st_d.ready = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.ready <= 1'b1;
            st_q.ie    <= 1'b0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready  = st_q.ready;
    assign ie     = st_q.ie;
    assign data   = st_q.data;
    assign strobe = last_d;
endmodule

// File: rtl/term_mmio.sv
module term_mmio
    import term_mmio_pkg::*;
#(
    parameter logic [31:0] BASE        = 32'hFFFF_0000,
    parameter int          BUSY_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        kb_valid,
    input  logic [7:0]  kb_byte,
    output logic        disp_strobe,
    output logic [7:0]  disp_byte,
    output logic        rx_irq,
    output logic        tx_irq
);
    logic [NUM_REGS-1:0] rd_sel, wr_sel;
    logic                rx_ready, rx_ie, tx_ready, tx_ie;
    logic [CHAR_W-1:0]   rx_char, tx_char;
    logic [DATA_W-1:0]   rdata_d;

    term_addr_dec #(.ADDR_W(32), .BASE(BASE)) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    term_rx_unit u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (kb_valid),
        .key_byte  (kb_byte),
        .ctrl_wr   (wr_sel[REG_RX_CTRL]),
        .ie_wval   (bus_wdata[BIT_IE]),
        .data_rd   (rd_sel[REG_RX_DATA]),
        .ready     (rx_ready),
        .ie        (rx_ie),
        .data      (rx_char)
    );

    term_tx_unit #(.BUSY_CYCLES(BUSY_CYCLES)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_sel[REG_TX_CTRL]),
        .ie_wval (bus_wdata[BIT_IE]),
        .data_wr (wr_sel[REG_TX_DATA]),
        .wchar   (bus_wdata[CHAR_W-1:0]),
        .ready   (tx_ready),
        .ie      (tx_ie),
        .data    (tx_char),
        .strobe  (disp_strobe)
    );

    always_comb begin
        rdata_d = '0;
        if (rd_sel[REG_RX_CTRL]) begin
            rdata_d[BIT_RDY] = rx_ready;
            rdata_d[BIT_IE]  = rx_ie;
        end
        if (rd_sel[REG_RX_DATA]) begin
            rdata_d[CHAR_W-1:0] = rx_char;
        end
        if (rd_sel[REG_TX_CTRL]) begin
            rdata_d[BIT_RDY] = tx_ready;
            rdata_d[BIT_IE]  = tx_ie;
        end
        if (rd_sel[REG_TX_DATA]) begin
            rdata_d[CHAR_W-1:0] = tx_char;
        end
    end

    assign bus_rdata = rdata_d;
    assign disp_byte = tx_char;
    assign rx_irq    = rx_ready & rx_ie;
    assign tx_irq    = tx_ready & tx_ie;
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
    parameter logic [31:0] BASE = 32'hFFFF_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        kb_valid,
    input logic        disp_strobe,
    input logic        rx_irq,
    input logic        tx_irq,
    input logic        rx_ready,
    input logic        rx_ie,
    input logic        tx_ready,
    input logic        tx_ie
);
    logic rxd_rd, txd_wr, mapped;

    always_comb begin
        rxd_rd = bus_rd && (bus_addr == BASE + 32'h4);
        txd_wr = bus_wr && (bus_addr == BASE + 32'hC);
        mapped = (bus_addr == BASE) || (bus_addr == BASE + 32'h4)
              || (bus_addr == BASE + 32'h8) || (bus_addr == BASE + 32'hC);
    end

    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) kb_valid |=> rx_ready); // R4
    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rxd_rd && !kb_valid) |=> !rx_ready); // R5
    AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (rx_ready && !rxd_rd) |=> rx_ready); // R9
    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) txd_wr |=> !tx_ready); // R6
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) disp_strobe |-> !tx_ready); // R7
    AST_STROBE_DONE: assert property (@(posedge clk) disable iff (!rst_n) (disp_strobe && !txd_wr) |=> tx_ready); // R7
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) disp_strobe |=> !disp_strobe); // R7
    AST_TX_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_ready) |-> $past(disp_strobe)); // R7
    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> (rx_ready && rx_ie)); // R10
    AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (tx_ready && tx_ie) |-> tx_irq); // R10
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[31:8] == 24'h0); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!bus_rd || !mapped) |-> (bus_rdata == 32'h0)); // R2
endmodule

bind term_mmio term_mmio_chk #(.BASE(BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .kb_valid    (kb_valid),
    .disp_strobe (disp_strobe),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq),
    .rx_ready    (rx_ready),
    .rx_ie       (rx_ie),
    .tx_ready    (tx_ready),
    .tx_ie       (tx_ie)
);

// File: tb/sim_term_mmio.sv
module sim_term_mmio;
    localparam int          BUSY = 16;
    localparam logic [31:0] RXC  = 32'hFFFF_0000;
    localparam logic [31:0] RXD  = 32'hFFFF_0004;
    localparam logic [31:0] TXC  = 32'hFFFF_0008;
    localparam logic [31:0] TXD  = 32'hFFFF_000C;

    localparam logic [1:0] OP_RD = 2'd1, OP_WR = 2'd2, OP_KEY = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,  RXC, 32'h0, 32'h0, 8'd1},
        '{OP_RD,  TXC, 32'h0, 32'h1, 8'd1},
        '{OP_KEY, RXC, 32'h41, 32'h0, 8'd4},
        '{OP_RD,  RXC, 32'h0, 32'h1, 8'd4},
        '{OP_RD,  RXD, 32'h0, 32'h41, 8'd4},
        '{OP_RD,  RXC, 32'h0, 32'h0, 8'd5},
        '{OP_WR,  RXC, 32'hFFFF_FFFF, 32'h0, 8'd3},
        '{OP_RD,  RXC, 32'h0, 32'h2, 8'd3},
        '{OP_WR,  RXD, 32'h55, 32'h0, 8'd5},
        '{OP_RD,  RXD, 32'h0, 32'h41, 8'd5},
        '{OP_RD,  32'hFFFF_0010, 32'h0, 32'h0, 8'd2},
        '{OP_KEY, RXC, 32'h5A, 32'h0, 8'd9},
        '{OP_KEY, RXC, 32'h33, 32'h0, 8'd9},
        '{OP_RD,  RXC, 32'h0, 32'h3, 8'd9},
        '{OP_RD,  RXD, 32'h0, 32'h33, 8'd9},
        '{OP_RD,  RXC, 32'h0, 32'h2, 8'd5},
        '{OP_WR,  RXC, 32'h0, 32'h0, 8'd3},
        '{OP_RD,  RXC, 32'h0, 32'h0, 8'd3},
        '{OP_WR,  TXC, 32'h2, 32'h0, 8'd3},
        '{OP_RD,  TXC, 32'h0, 32'h3, 8'd3},
        '{OP_RD,  32'h0000_0000, 32'h0, 32'h0, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_byte = '0;
    logic        disp_strobe;
    logic [7:0]  disp_byte;
    logic        rx_irq, tx_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    term_mmio #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_byte(kb_byte), .disp_strobe(disp_strobe),
        .disp_byte(disp_byte), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #2;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_key(input logic [7:0] b);
        kb_byte  = b;
        kb_valid = 1'b1;
        @(posedge clk);
        #1;
        kb_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int          strobes;
        logic [7:0]  seen;

        tick(3);
        check("R1 strobe in reset", {31'b0, disp_strobe}, 32'h0);
        rst_n = 1'b1;
        tick(1);
        check("R1 rx_irq", {31'b0, rx_irq}, 32'h0);
        check("R1 tx_irq", {31'b0, tx_irq}, 32'h0);
        do_read(RXD, rd);
        check("R1 rx char", rd, 32'h0);
        do_read(TXD, rd);
        check("R1 tx char", rd, 32'h0);

        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                OP_RD: begin
                    do_read(VECS[v].addr, rd);
                    check($sformatf("R%0d vector %0d", VECS[v].req, v), rd, VECS[v].exp);
                end
                OP_WR:  do_write(VECS[v].addr, VECS[v].wdata);
                OP_KEY: do_key(VECS[v].wdata[7:0]);
                default: tick(1);
            endcase
        end

        // R10: receive interrupt gated by enable
        do_key(8'h10);
        check("R10 rx_irq with ie=0", {31'b0, rx_irq}, 32'h0);
        do_write(RXC, 32'h2);
        check("R10 rx_irq with ie=1", {31'b0, rx_irq}, 32'h1);

        // R9: read of receive data together with a new key keeps ready
        bus_addr = RXD;
        bus_rd   = 1'b1;
        kb_byte  = 8'h77;
        kb_valid = 1'b1;
        @(posedge clk);
        #1;
        bus_rd   = 1'b0;
        kb_valid = 1'b0;
        check("R9 ready after read+key", {31'b0, rx_irq}, 32'h1);
        do_read(RXD, rd);
        check("R9 byte after read+key", rd, 32'h77);
        check("R5 ready cleared by read", {31'b0, rx_irq}, 32'h0);

        // R7 / R6: busy interval and strobe
        check("R10 tx_irq idle", {31'b0, tx_irq}, 32'h1);
        do_write(TXD, 32'h1234_5648);
        do_read(TXD, rd);
        check("R6 tx char readback", rd, 32'h48);
        strobes = 0;
        seen    = 8'h0;
        for (int i = 1; i < BUSY; i++) begin
            if (tx_irq) begin
                check($sformatf("R7 ready early at %0d", i), 32'h1, 32'h0);
            end
            if (disp_strobe) begin
                strobes++;
                seen = disp_byte;
                if (i != BUSY - 1) check($sformatf("R7 strobe early at %0d", i), 32'h1, 32'h0);
            end
            tick(1);
        end
        check("R7 strobe count", strobes, 1);
        check("R7 strobed byte", {24'b0, seen}, 32'h48);
        check("R7 ready back", {31'b0, tx_irq}, 32'h1);
        check("R7 strobe low after", {31'b0, disp_strobe}, 32'h0);

        // R8: write during busy restarts the interval
        do_write(TXD, 32'h61);
        tick(5);
        do_write(TXD, 32'h62);
        strobes = 0;
        seen    = 8'h0;
        for (int i = 0; i < BUSY; i++) begin
            if (disp_strobe) begin
                strobes++;
                seen = disp_byte;
                if (i != BUSY - 1) check($sformatf("R8 strobe at %0d", i), 32'h1, 32'h0);
            end
            tick(1);
        end
        check("R8 single strobe", strobes, 1);
        check("R8 new byte strobed", {24'b0, seen}, 32'h62);
        check("R8 ready back", {31'b0, tx_irq}, 32'h1);
        do_read(TXC, rd);
        check("R3 tx ctrl after busy", rd, 32'h3);
        do_write(TXC, 32'h0000_0001);
        do_read(TXC, rd);
        check("R3 ready bit not writable", rd, 32'h1);

        // R1: reset during busy interval
        do_write(TXD, 32'h99);
        tick(3);
        rst_n = 1'b0;
        tick(2);
        check("R1 strobe low in reset", {31'b0, disp_strobe}, 32'h0);
        rst_n = 1'b1;
        tick(1);
        do_read(TXC, rd);
        check("R1 tx ctrl after reset", rd, 32'h1);
        do_read(RXC, rd);
        check("R1 rx ctrl after reset", rd, 32'h0);
        do_read(TXD, rd);
        check("R1 tx char after reset", rd, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule